// File: doc/BRIEF.md
# Timer Block External Clock Router

This block sits beside a group of three timer channels and decides which signal each channel sees as its external clock or event input. Every channel has its own two-bit selector with a fixed menu. The menu offers the channel's own pin clock, a constant low "off" level, or the waveform output of either of the two other channels. Routing one channel's waveform output into another channel lets timers be chained.

Pin clocks come from outside the system clock domain. They pass through a synchroniser before the selector. Waveform outputs come from the channels inside the block and are taken directly. The selected level is registered. Rising and falling edges of that level are reported as single-cycle pulses in the system clock domain.

A write-only control command makes one system-clock pulse that goes to all three channels at once, so their counters restart together. Software reaches the selectors and the command through a small register port. The port has a write side and a combinational read side.

Top module: `tcr_top`

## Requirements
- R1: While reset is held and after its release, ext_clk_o, ext_rise_o, ext_fall_o and sync_o are all zero. The mode register holds 0x15, which selects "off" on every channel.
- R2: A write to address 1 stores wr_data_i[5:0] in the mode register. Reading address 1 returns that value in bits [5:0], with zeros in all higher bits. Addresses 2 and 3 read as zero and ignore writes.
- R3: Mode bits [2c+1:2c] hold channel c's selector. Code 1 drives channel c's output low, whatever the pin and waveform inputs do.
- R4: Code 0 routes pin_clk_i[c] to ext_clk_o[c]. A change on the pin shows on the output after the third rising clock edge: two synchroniser stages and then the output register.
- R5: Code 2 routes the lower-numbered other channel's tioa_i, and code 3 routes the higher-numbered one. That is: channel 0 takes 1 and 2, channel 1 takes 0 and 2, and channel 2 takes 0 and 1. A waveform input reaches the output after one rising edge.
- R6: ext_rise_o[c] is high for exactly the first cycle in which ext_clk_o[c] is 1 after being 0. ext_fall_o[c] is high for exactly the first cycle in which it is 0 after being 1.
- R7: A write to address 0 with wr_data_i[0]=1 makes all three bits of sync_o high for exactly the one cycle after that write edge. A write to address 0 with bit 0 clear gives no pulse.
- R8: Reading address 0 always returns zero.
- R9: A new selector value takes effect at the first rising edge after the write edge. Each channel's selector is independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 mode) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| pin_clk_i | input | 3 | Asynchronous pin clocks, one per channel |
| tioa_i | input | 3 | Waveform outputs of the three channels |
| ext_clk_o | output | 3 | Selected external level per channel |
| ext_rise_o | output | 3 | Rising edge pulse of the selected level |
| ext_fall_o | output | 3 | Falling edge pulse of the selected level |
| sync_o | output | 3 | Common counter restart pulse |

## Verification
Random pin and waveform activity runs against random selector rewrites. This shows whether each code picks the right source, because the four candidate inputs of a channel toggle independently. It also separates the three-edge pin latency from the one-edge waveform latency. Directed sequences cover these cases:
- reset values;
- "off" selection while every input toggles;
- control writes with bit 0 set or clear, including back-to-back writes;
- reads of the control and unused addresses.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int NUM_CH = 3;
  localparam int SEL_W  = 2;
  localparam int MODE_W = NUM_CH * SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_PIN  = 2'd0,
    SRC_OFF  = 2'd1,
    SRC_PEER_LO = 2'd2,
    SRC_PEER_HI = 2'd3
  } src_sel_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;

  // lower-numbered and higher-numbered of the other channels
  function automatic int peer_lo(int ch);
    return (ch == 0) ? 1 : 0;
  endfunction

  function automatic int peer_hi(int ch);
    return (ch == NUM_CH - 1) ? NUM_CH - 2 : NUM_CH - 1;
  endfunction

  function automatic logic [MODE_W-1:0] mode_rst();
    logic [MODE_W-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i*SEL_W +: SEL_W] = SRC_OFF;
    return v;
  endfunction
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tcr_regs.sv
module tcr_regs
  import tcr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              sync_o
);
  localparam logic [MODE_W-1:0] MODE_RST = mode_rst();

  logic [MODE_W-1:0] mode_q;
  logic              sync_q;
  logic              wr_mode, wr_ctrl, ctrl_set;
  logic              unused_wdata;

  assign wr_mode  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MODE));
  assign wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign ctrl_set = wr_ctrl && wr_data_i[0];
  assign unused_wdata = ^wr_data_i[DATA_W-1:MODE_W];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      mode_q <= MODE_RST;
    else if (wr_mode) mode_q <= wr_data_i[MODE_W-1:0];

  // control is write-only: a set bit becomes a single pulse
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= ctrl_set;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_MODE)) rd_data_o[MODE_W-1:0] = mode_q;
  end

  assign mode_o = mode_q;
  assign sync_o = sync_q;

  p_mode_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> mode_q == $past(wr_data_i[MODE_W-1:0]));

  p_sync_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && !ctrl_set) |=> !sync_q);
endmodule

// File: rtl/tcr_src_mux.sv
module tcr_src_mux
  import tcr_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pin_i,
  input  logic [NUM_CH-1:0] tioa_i,
  output logic              ext_o
);
  localparam int LO = peer_lo(CH);
  localparam int HI = peer_hi(CH);

  logic ext_d, ext_q;

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_PIN:     ext_d = pin_i;
      SRC_OFF:     ext_d = 1'b0;
      SRC_PEER_LO: ext_d = tioa_i[LO];
      SRC_PEER_HI: ext_d = tioa_i[HI];
      default:     ext_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_d;

  assign ext_o = ext_q;

  p_off_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_OFF) |=> !ext_q);

  p_peer_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_PEER_LO) |=> ext_q == $past(tioa_i[LO]));

  p_peer_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_PEER_HI) |=> ext_q == $past(tioa_i[HI]));
endmodule

// File: rtl/tcr_edge.sv
module tcr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  p_rise_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  p_fall_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tcr_top.sv
module tcr_top
  import tcr_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NUM_CH-1:0] pin_clk_i,
  input  logic [NUM_CH-1:0] tioa_i,
  output logic [NUM_CH-1:0] ext_clk_o,
  output logic [NUM_CH-1:0] ext_rise_o,
  output logic [NUM_CH-1:0] ext_fall_o,
  output logic [NUM_CH-1:0] sync_o
);
  logic [NUM_CH-1:0] pin_s;
  logic [MODE_W-1:0] mode;
  logic              sync_pulse;

  tcr_sync #(.STAGES(SYNC_STAGES), .W(NUM_CH)) u_pin_sync (
    .clk_i, .rst_ni, .d_i(pin_clk_i), .q_o(pin_s)
  );

  tcr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o, .mode_o(mode), .sync_o(sync_pulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tcr_src_mux #(.CH(c)) u_mux (
      .clk_i, .rst_ni,
      .sel_i (mode[c*SEL_W +: SEL_W]),
      .pin_i (pin_s[c]),
      .tioa_i,
      .ext_o (ext_clk_o[c])
    );
    tcr_edge u_edge (
      .clk_i, .rst_ni,
      .lvl_i  (ext_clk_o[c]),
      .rise_o (ext_rise_o[c]),
      .fall_o (ext_fall_o[c])
    );
  end

  assign sync_o = {NUM_CH{sync_pulse}};
endmodule

// File: tb/tcr_top_tb_top.sv
module tcr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd1;
  logic [31:0] rd_data;
  logic [2:0]  pin_clk = '0, tioa = '0;
  logic [2:0]  ext_clk, ext_rise, ext_fall, sync_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tcr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pin_clk_i(pin_clk), .tioa_i(tioa), .ext_clk_o(ext_clk),
    .ext_rise_o(ext_rise), .ext_fall_o(ext_fall), .sync_o(sync_o)
  );

  // reference model built from the requirement latencies
  logic [2:0] m_p1, m_p2, m_ext, m_prev, m_sync;
  logic [5:0] m_mode;

  function automatic logic pick(int ch, logic [1:0] code, logic [2:0] pin, logic [2:0] ta);
    case (code)
      2'd0: return pin[ch];
      2'd1: return 1'b0;
      2'd2: return (ch == 0) ? ta[1] : ta[0];
      default: return (ch == 2) ? ta[1] : ta[2];
    endcase
  endfunction

  function automatic string ch_tag(logic [1:0] code);
    case (code)
      2'd0: return "R4";
      2'd1: return "R3";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_p1 <= '0; m_p2 <= '0; m_ext <= '0; m_prev <= '0;
      m_mode <= 6'h15; m_sync <= '0;
    end else begin
      m_p1 <= pin_clk;
      m_p2 <= m_p1;
      for (int c = 0; c < 3; c++) m_ext[c] <= pick(c, m_mode[2*c +: 2], m_p2, tioa);
      m_prev <= m_ext;
      if (wr_en && wr_addr == 2'd1) m_mode <= wr_data[5:0];
      m_sync <= {3{wr_en && wr_addr == 2'd0 && wr_data[0]}};
    end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] exp_rd;
    for (int c = 0; c < 3; c++)
      chk(ch_tag(m_mode[2*c +: 2]), 32'(ext_clk[c]), 32'(m_ext[c]));
    chk("R6 rise", 32'(ext_rise), 32'(m_ext & ~m_prev));
    chk("R6 fall", 32'(ext_fall), 32'(~m_ext & m_prev));
    chk("R7 sync", 32'(sync_o), 32'(m_sync));
    exp_rd = (rd_addr == 2'd1) ? {26'b0, m_mode} : 32'b0;
    chk((rd_addr == 2'd0) ? "R8 rd" : "R2 rd", rd_data, exp_rd);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    wr_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    compare_all();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    // R1: reset state while held
    pin_clk = 3'b111; tioa = 3'b111;
    repeat (3) @(negedge clk);
    chk("R1 ext", 32'(ext_clk), 0);
    chk("R1 sync", 32'(sync_o), 0);
    chk("R1 mode", rd_data, 32'h15);
    rst_n = 1'b1;
    // R1/R3: all off after release, inputs high
    repeat (6) step();
    // R7: bit0 clear gives no pulse, then set, then back-to-back
    wr(2'd0, 32'hFFFF_FFFE); step(); step();
    wr(2'd0, 32'h1); step(); step();
    wr(2'd0, 32'h1); wr(2'd0, 32'h1); step(); step();
    // R2: upper bits and unused addresses
    wr(2'd1, 32'hFFFF_FFC6); step();
    wr(2'd2, 32'h0000_003F); wr(2'd3, 32'h0); step();
    rd_addr = 2'd2; step(); rd_addr = 2'd0; step(); rd_addr = 2'd1; step();
    // R4: all pins, staggered toggles
    wr(2'd1, 32'h00); step();
    for (int i = 0; i < 12; i++) begin pin_clk = pin_clk ^ 3'(1 << (i % 3)); step(); end
    // R5/R9: each peer code, channels independent
    for (int m = 0; m < 64; m++) begin
      wr(2'd1, 32'(m));
      for (int i = 0; i < 6; i++) begin tioa = 3'($urandom); pin_clk = 3'($urandom); step(); end
    end
    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      pin_clk = 3'($urandom); tioa = 3'($urandom); rd_addr = 2'($urandom);
      wr_en = ($urandom % 6) == 0;
      wr_addr = 2'($urandom);
      wr_data = $urandom;
    end
    wr_en = 1'b0;
    repeat (4) step();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule